// File: doc/BRIEF.md
# Fast Interrupt Request Controller

This block collects sixteen fast interrupt request lines for a single-issue CPU, turns each rising edge into a sticky pending bit, and tells the pipeline which channel it should service next. Every channel has its own enable bit, and one global enable gates all channels. Software reads the pending bits and clears them with a one-cycle clear mask. A channel's pending bit is also dropped when its enable bit is written to zero.

When the global enable is set and at least one enabled channel is pending, the controller raises `irq_valid_o`. It drives `cause_o` with the code of the lowest-numbered pending channel: bit 31 is set and the lower bits hold a fixed base plus the channel index. The pipeline raises `irq_ready_i` only between two instructions. The cycle in which valid and ready are both high is the cycle the interrupt is taken, and the controller marks that cycle on `take_o`. This is a request flag, not a data stream, so it has no back-pressure rule. `cause_o` may change while valid waits for ready, for example when a higher-priority channel becomes pending or software clears the current one. Taking an interrupt does not clear its pending bit. The handler must clear it, and lower-priority channels keep waiting.

Top module: `firq_ctrl`

## Requirements
- R1: A 0-to-1 transition on `irq_lines_i[k]` of an enabled channel sets `pend_o[k]` after the next rising clock edge.
- R2: A line held high does not set its pending bit again once it has been cleared. Only a new 0-to-1 transition sets it.
- R3: A pending bit stays set until software clears it or its enable bit is written to 0. Taking the interrupt does not clear it.
- R4: A 1 in `pend_clr_i[k]` for one cycle clears `pend_o[k]` at the next clock edge. A 0 in the mask leaves the bit unchanged.
- R5: A clear and a new rising edge on the same channel in the same cycle leave the pending bit set.
- R6: A rising edge on a channel whose enable bit is 0 is ignored. Writing 0 to an enable bit (`en_wr_i`, `en_wdata_i`) clears that channel's pending bit at the same edge at which the enable register updates.
- R7: After reset, `pend_o`, `en_o` and `gie_o` are all 0. `irq_valid_o` is 1 exactly when `gie_o` is 1 and `pend_o` is nonzero.
- R8: The lowest-numbered pending channel has priority. `cause_o` is 0x80000000 + 16 + index.
- R9: `take_o` is 1 exactly in cycles where `irq_valid_o` and `irq_ready_i` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | 16 | Fast request lines, rising-edge sensitive |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 16 | New per-channel enable bits |
| gie_wr_i | input | 1 | Write strobe for the global enable |
| gie_wdata_i | input | 1 | New global enable value |
| pend_clr_i | input | 16 | One-cycle clear mask for pending bits |
| irq_ready_i | input | 1 | Pipeline is at an instruction boundary and can take an interrupt |
| en_o | output | 16 | Current per-channel enable bits |
| gie_o | output | 1 | Current global enable |
| pend_o | output | 16 | Current pending bits |
| irq_valid_o | output | 1 | An interrupt is requested |
| cause_o | output | 32 | Cause code of the selected channel |
| take_o | output | 1 | Interrupt taken this cycle |

## Verification
The hardest cases to reach are two events that land on one channel in the same cycle. One is a software clear arriving exactly as a new edge does. The other is an enable write to 0 while the line is already high. The stimulus table lines these up by driving a line's new value and the matching clear mask bit in the same cycle. A directed sequence holds a line high across a disable and a re-enable to show that only a fresh transition is captured. Handshake cycles are checked with several channels pending, so a wrong clear-on-take would show up in the pending bits.

// File: rtl/firq_pkg.sv
package firq_pkg;
  localparam int unsigned FIRQ_N     = 16;
  localparam int unsigned FIRQ_IDX_W = $clog2(FIRQ_N);
  localparam int unsigned FIRQ_XLEN  = 32;
  localparam int unsigned FIRQ_BASE  = 16;

  typedef logic [FIRQ_N-1:0] firq_vec_t;
endpackage

// File: rtl/firq_edge.sv
module firq_edge #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lines_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lines_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_rise
    assign rise_o[g] = lines_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/firq_pend.sv
module firq_pend #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_next_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    // a new edge wins over a clear; a disabled channel holds nothing
    assign pend_d[g] = ((pend_q[g] & ~clr_i[g]) | rise_i[g]) & en_next_i[g];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/firq_prio.sv
module firq_prio #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/firq_ctrl.sv
module firq_ctrl
  import firq_pkg::*;
#(
  parameter int unsigned N     = FIRQ_N,
  parameter int unsigned XLEN  = FIRQ_XLEN,
  parameter int unsigned BASE  = FIRQ_BASE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    irq_lines_i,
  input  logic            en_wr_i,
  input  logic [N-1:0]    en_wdata_i,
  input  logic            gie_wr_i,
  input  logic            gie_wdata_i,
  input  logic [N-1:0]    pend_clr_i,
  input  logic            irq_ready_i,
  output logic [N-1:0]    en_o,
  output logic            gie_o,
  output logic [N-1:0]    pend_o,
  output logic            irq_valid_o,
  output logic [XLEN-1:0] cause_o,
  output logic            take_o
);
  localparam int unsigned IDX_W = $clog2(N);

  logic [N-1:0]     en_q, en_d;
  logic             gie_q;
  logic [N-1:0]     rise;
  logic [N-1:0]     pend;
  logic             any_pend;
  logic [IDX_W-1:0] win_idx;

  assign en_d = en_wr_i ? en_wdata_i : en_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      en_q <= en_d;
      if (gie_wr_i) gie_q <= gie_wdata_i;
    end
  end

  firq_edge #(.N(N)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (irq_lines_i),
    .rise_o  (rise)
  );

  firq_pend #(.N(N)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .clr_i     (pend_clr_i),
    .en_next_i (en_d),
    .pend_o    (pend)
  );

  firq_prio #(.N(N), .IDX_W(IDX_W)) u_prio (
    .req_i (pend),
    .any_o (any_pend),
    .idx_o (win_idx)
  );

  assign en_o        = en_q;
  assign gie_o       = gie_q;
  assign pend_o      = pend;
  assign irq_valid_o = gie_q & any_pend;
  assign cause_o     = {1'b1, (XLEN-1)'(BASE) + (XLEN-1)'(win_idx)};
  assign take_o      = irq_valid_o & irq_ready_i;
endmodule

// File: rtl/firq_ctrl_chk.sv
module firq_ctrl_chk #(
  parameter int unsigned N    = 16,
  parameter int unsigned XLEN = 32,
  parameter int unsigned BASE = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_wr_i,
  input logic [N-1:0]    pend_clr_i,
  input logic            irq_ready_i,
  input logic [N-1:0]    en_o,
  input logic            gie_o,
  input logic [N-1:0]    pend_o,
  input logic            irq_valid_o,
  input logic [XLEN-1:0] cause_o,
  input logic            take_o
);
  logic [N-1:0] below;
  logic         sel_hit;

  always_comb begin
    below   = '0;
    sel_hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (cause_o[XLEN-2:0] > (XLEN-1)'(BASE + i)) below[i] = 1'b1;
      if (cause_o[XLEN-2:0] == (XLEN-1)'(BASE + i)) sel_hit = pend_o[i];
    end
  end

  // R6: no channel is pending while disabled
  p_pend_in_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & ~en_o) == '0);

  // R7: a request needs the global enable and a pending channel
  p_valid_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (gie_o && pend_o != '0));

  // R8: the selected channel is pending, interrupt flag set, nothing lower pending
  p_cause_prio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (cause_o[XLEN-1] && sel_hit && (pend_o & below) == '0));

  // R9: taken only on a handshake
  p_take_hs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (irq_valid_o && irq_ready_i));

  // R3: without clear or enable write, pending bits never drop
  p_pend_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_clr_i == '0 && !en_wr_i) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

bind firq_ctrl firq_ctrl_chk #(.N(N), .XLEN(XLEN), .BASE(BASE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_wr_i     (en_wr_i),
  .pend_clr_i  (pend_clr_i),
  .irq_ready_i (irq_ready_i),
  .en_o        (en_o),
  .gie_o       (gie_o),
  .pend_o      (pend_o),
  .irq_valid_o (irq_valid_o),
  .cause_o     (cause_o),
  .take_o      (take_o)
);

// File: tb/test_firq_ctrl.sv
module test_firq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] lines, en_wdata, clr, en_q, pend;
  logic        en_wr, gie_wr, gie_wdata, ready, gie, valid, take;
  logic [31:0] cause;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  firq_ctrl i_firq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .gie_wr_i(gie_wr), .gie_wdata_i(gie_wdata),
    .pend_clr_i(clr), .irq_ready_i(ready),
    .en_o(en_q), .gie_o(gie), .pend_o(pend),
    .irq_valid_o(valid), .cause_o(cause), .take_o(take)
  );

  // {lines, clear mask, expected pending}
  localparam int NV = 9;
  localparam logic [47:0] VEC [NV] = '{
    {16'h0001, 16'h0000, 16'h0001},  // R1 edge captured
    {16'h0001, 16'h0001, 16'h0000},  // R2 R4 held level, cleared
    {16'h0000, 16'h0000, 16'h0000},
    {16'h8010, 16'h0000, 16'h8010},  // R1 two edges
    {16'h8011, 16'h0010, 16'h8001},  // R4 clear one, edge another
    {16'h0000, 16'h0000, 16'h8001},  // R3 stays pending
    {16'h0010, 16'h0010, 16'h8011},  // R5 clear and edge together
    {16'h0000, 16'h8001, 16'h0010},  // R4
    {16'h0000, 16'h0010, 16'h0000}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cause(input logic [15:0] p);
    for (int i = 0; i < 16; i++) if (p[i]) return 32'h8000_0000 + 32'(16 + i);
    return 32'h8000_0010;
  endfunction

  // drive at a falling edge, return at the next falling edge (one rising edge between)
  task automatic step();
    @(negedge clk);
    clr = '0; en_wr = 1'b0; gie_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lines = '0; en_wdata = '0; clr = '0;
    en_wr = 1'b0; gie_wr = 1'b0; gie_wdata = 1'b0; ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset state
    chk("R7 pend reset", 32'(pend), 0);
    chk("R7 en reset",   32'(en_q), 0);
    chk("R7 gie reset",  32'(gie), 0);
    chk("R7 valid reset", 32'(valid), 0);

    en_wr = 1'b1; en_wdata = 16'hFFFF; gie_wr = 1'b1; gie_wdata = 1'b1;
    step();

    for (int v = 0; v < NV; v++) begin
      lines = VEC[v][47:32];
      clr   = VEC[v][31:16];
      step();
      chk("R1-table pend", 32'(pend), 32'(VEC[v][15:0]));
      chk("R7 valid", 32'(valid), 32'(VEC[v][15:0] != 0));
      if (VEC[v][15:0] != 0) chk("R8 cause", cause, exp_cause(VEC[v][15:0]));
    end

    // R7 global enable gating
    lines = 16'h0024; step();
    chk("R1 pend 0024", 32'(pend), 32'h0024);
    gie_wr = 1'b1; gie_wdata = 1'b0; step();
    chk("R7 valid gie off", 32'(valid), 0);
    ready = 1'b1; #1;
    chk("R9 no take gie off", 32'(take), 0);
    ready = 1'b0;
    gie_wr = 1'b1; gie_wdata = 1'b1; step();
    chk("R7 valid gie on", 32'(valid), 1);
    chk("R8 cause ch2", cause, 32'h8000_0012);

    // R9 handshake, R3 take does not clear
    #1; chk("R9 no take without ready", 32'(take), 0);
    ready = 1'b1; #1;
    chk("R9 take", 32'(take), 1);
    step();
    ready = 1'b0;
    chk("R3 pend after take", 32'(pend), 32'h0024);
    clr = 16'h0024; lines = '0; step();
    chk("R4 cleared", 32'(pend), 0);

    // R6 disabled channel ignores edge
    en_wr = 1'b1; en_wdata = 16'hFFF7; step();
    lines = 16'h0008; step();
    chk("R6 disabled edge ignored", 32'(pend), 0);
    // R2 re-enable with line still high: no capture
    en_wr = 1'b1; en_wdata = 16'hFFFF; step();
    step();
    chk("R2 level after enable", 32'(pend), 0);
    lines = 16'h0000; step();
    lines = 16'h0008; step();
    chk("R1 edge ch3", 32'(pend), 32'h0008);
    // R6 disable clears pending with the enable update
    en_wr = 1'b1; en_wdata = 16'hFFF7; step();
    chk("R6 disable clears", 32'(pend), 0);
    chk("R6 enable value", 32'(en_q), 32'hFFF7);
    chk("R7 valid none", 32'(valid), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule